// File: doc/BRIEF.md
# VLAN Header Rewrite and Queue Descriptor Formatter

This block takes one lookup result per packet and turns it into two outputs. The first is a short stream of 32-bit memory writes that rebuild the stored Ethernet header of the packet as a VLAN-tagged frame. That header holds a destination MAC, a source MAC, the 802.1Q tag and, optionally, the IPv4 Ethertype. The second is a packed enqueue descriptor for a downstream queue manager. The descriptor carries the queue number, the output port, the full Ethernet frame length and a stats index that later counters will use.

The local MAC address is loaded once after reset through a configuration strobe, and the block uses it unchanged from then on. The rewritten destination MAC shares its upper five bytes with that local address. Only its last byte comes from the lookup result. The frame length is the IP packet length plus the 18-byte VLAN Ethernet header. The block handles one packet at a time. It emits every header write, then offers the descriptor, and only then accepts the next lookup result. Descriptors therefore leave in arrival order, and backpressure on either output holds the input off.

Top module: `vlan_hdr_rewriter`

## Requirements
- R1: The first `cfgLoad` pulse after reset latches `cfgMac` as the local MAC, and any later pulse is ignored. `lkReady` stays low until the first load.
- R2: Header words go out most significant byte first. With local MAC `S` and destination MAC `D = {S[47:8], lkDstByte}`, word 0 is `D[47:16]`, word 1 is `{D[15:0], S[47:32]}` and word 2 is `S[31:0]`.
- R3: Word 3 is `{16'h8100, lkVlan}`, so the tag value is copied from the lookup result.
- R4: Each packet produces exactly four writes when `lkFiveWr`=0 and exactly five when `lkFiveWr`=1. Word k goes to address `lkHandle + 4*k`. Words 0 to 3 carry `wrByteEn`=4'b1111. The fifth word is `{16'h0800, 16'h0000}` with `wrByteEn`=4'b1100.
- R5: The descriptor frame length equals `lkIpLen + 18`, taken modulo 2^16.
- R6: The 96-bit descriptor is packed as follows: stats index [95:80], buffer handle [79:48], frame length [47:32], QID [31:12], port [7:4].
- R7: The reserved descriptor fields [11:8] and [3:0] are always zero.
- R8: Only one packet is in flight at a time. `lkReady` is low while writes or the descriptor are pending. All writes of a packet come before its descriptor, and descriptors follow lookup order.
- R9: While `wrValid` or `descValid` is high without its ready signal, the valid stays high and the address, data and descriptor hold steady.
- R10: During and directly after reset, `lkReady`, `wrValid` and `descValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Strobe that loads the local MAC (first pulse only) |
| cfgMac | input | 48 | Local MAC address value |
| lkValid | input | 1 | Lookup result valid |
| lkReady | output | 1 | Block can accept a lookup result |
| lkHandle | input | 32 | Buffer handle, base address of the stored header |
| lkIpLen | input | 16 | IP packet length in bytes |
| lkQid | input | 20 | Queue number |
| lkVlan | input | 16 | VLAN tag control field |
| lkStats | input | 16 | Stats index |
| lkDstByte | input | 8 | Last byte of the destination MAC |
| lkPort | input | 4 | Output port number |
| lkFiveWr | input | 1 | 1 = also rewrite the Ethertype word (five writes) |
| wrValid | output | 1 | Header write valid |
| wrReady | input | 1 | Header write accepted |
| wrAddr | output | 32 | Byte address of the header word |
| wrData | output | 32 | Header word, network byte order |
| wrByteEn | output | 4 | Byte enables, bit 3 = most significant byte |
| descValid | output | 1 | Descriptor valid |
| descReady | input | 1 | Descriptor accepted |
| desc | output | 96 | Packed enqueue descriptor |

## Verification
The bound checker watches four things on every cycle. It confirms that no lookup is accepted before the MAC is loaded or while a packet is pending. It confirms that both outputs hold valid and contents steady under backpressure and that the reserved descriptor nibbles are zero. It also checks the frame length and the MAC-bearing words 0 and 2 against values it captured at the handshakes. The directed scenarios are needed for the rest. They show the exact word sequence and byte enables for both write counts and the length wrap at the 16-bit limit. They also show that a second configuration pulse leaves the MAC unchanged and that back-to-back packets come out in order with the full descriptor packing.

// File: rtl/hdr_rw_pkg.sv
package hdr_rw_pkg;
  parameter int MAC_W     = 48;
  parameter int WORD_W    = 32;
  parameter int HANDLE_W  = 32;
  parameter int LEN_W     = 16;
  parameter int QID_W     = 20;
  parameter int VLAN_W    = 16;
  parameter int STATS_W   = 16;
  parameter int PORT_W    = 4;
  parameter int RSV_W     = 4;
  parameter int BYTE_W    = 8;
  parameter int MAX_WORDS = 5;
  parameter int VLAN_HDR_LEN = 18;

  localparam int WORD_BYTES = WORD_W / BYTE_W;
  localparam int IDX_W   = $clog2(MAX_WORDS);
  localparam int DESC_W  = STATS_W + HANDLE_W + LEN_W + QID_W + RSV_W + PORT_W + RSV_W;
  localparam int HALF_W  = WORD_W / 2;

  localparam logic [HALF_W-1:0] TPID_VLAN  = 16'h8100;
  localparam logic [HALF_W-1:0] ETYPE_IPV4 = 16'h0800;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_DESC  = 2'd2
  } rwState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch lookup fields, clear word index
    logic advance;   // current header word accepted
  } rwCtrl_t;

  function automatic logic [DESC_W-1:0] packDesc(
    input logic [STATS_W-1:0]  stats,
    input logic [HANDLE_W-1:0] handle,
    input logic [LEN_W-1:0]    frameLen,
    input logic [QID_W-1:0]    qid,
    input logic [PORT_W-1:0]   port
  );
    return {stats, handle, frameLen, qid, {RSV_W{1'b0}}, port, {RSV_W{1'b0}}};
  endfunction
endpackage

// File: rtl/hdr_rw_ctrl.sv
module hdr_rw_ctrl
  import hdr_rw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    macLoaded,
  input  logic    lastWord,
  input  logic    lkValid,
  output logic    lkReady,
  output logic    wrValid,
  input  logic    wrReady,
  output logic    descValid,
  input  logic    descReady,
  output rwCtrl_t ctrl
);
  rwState_t state, stateNext;

  always_comb begin
    lkReady      = (state == ST_IDLE) && macLoaded;
    wrValid      = (state == ST_WRITE);
    descValid    = (state == ST_DESC);
    ctrl.capture = lkValid && lkReady;
    ctrl.advance = wrValid && wrReady;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (ctrl.capture) stateNext = ST_WRITE;
      ST_WRITE: if (ctrl.advance && lastWord) stateNext = ST_DESC;
      ST_DESC:  if (descReady) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/hdr_rw_datapath.sv
module hdr_rw_datapath
  import hdr_rw_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgLoad,
  input  logic [MAC_W-1:0]    cfgMac,
  input  logic [HANDLE_W-1:0] lkHandle,
  input  logic [LEN_W-1:0]    lkIpLen,
  input  logic [QID_W-1:0]    lkQid,
  input  logic [VLAN_W-1:0]   lkVlan,
  input  logic [STATS_W-1:0]  lkStats,
  input  logic [BYTE_W-1:0]   lkDstByte,
  input  logic [PORT_W-1:0]   lkPort,
  input  logic                lkFiveWr,
  input  rwCtrl_t             ctrl,
  output logic                macLoaded,
  output logic                lastWord,
  output logic [HANDLE_W-1:0] wrAddr,
  output logic [WORD_W-1:0]   wrData,
  output logic [WORD_BYTES-1:0] wrByteEn,
  output logic [DESC_W-1:0]   desc
);
  logic [MAC_W-1:0]    srcMac;
  logic [HANDLE_W-1:0] hHandle;
  logic [LEN_W-1:0]    hIpLen;
  logic [QID_W-1:0]    hQid;
  logic [VLAN_W-1:0]   hVlan;
  logic [STATS_W-1:0]  hStats;
  logic [BYTE_W-1:0]   hDst;
  logic [PORT_W-1:0]   hPort;
  logic                hFive;
  logic [IDX_W-1:0]    wordIdx;

  logic [MAC_W-1:0]    dstMac;
  logic [LEN_W-1:0]    frameLen;
  logic [WORD_W-1:0]   hdrWord [MAX_WORDS];

  // local MAC: first load after reset wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcMac    <= '0;
      macLoaded <= 1'b0;
    end else if (cfgLoad && !macLoaded) begin
      srcMac    <= cfgMac;
      macLoaded <= 1'b1;
    end
  end

  // per-packet holding registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hHandle <= '0; hIpLen <= '0; hQid <= '0; hVlan <= '0;
      hStats  <= '0; hDst   <= '0; hPort <= '0; hFive <= 1'b0;
    end else if (ctrl.capture) begin
      hHandle <= lkHandle; hIpLen <= lkIpLen; hQid  <= lkQid;
      hVlan   <= lkVlan;   hStats <= lkStats; hDst  <= lkDstByte;
      hPort   <= lkPort;   hFive  <= lkFiveWr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              wordIdx <= '0;
    else if (ctrl.capture)  wordIdx <= '0;
    else if (ctrl.advance)  wordIdx <= wordIdx + IDX_W'(1);
  end

  assign dstMac   = {srcMac[MAC_W-1:BYTE_W], hDst};
  assign frameLen = hIpLen + LEN_W'(VLAN_HDR_LEN);

  // header image, 18 bytes laid across five words
  always_comb begin
    hdrWord[0] = dstMac[MAC_W-1 -: WORD_W];
    hdrWord[1] = {dstMac[HALF_W-1:0], srcMac[MAC_W-1 -: HALF_W]};
    hdrWord[2] = srcMac[WORD_W-1:0];
    hdrWord[3] = {TPID_VLAN, hVlan};
    hdrWord[4] = {ETYPE_IPV4, {HALF_W{1'b0}}};
  end

  always_comb begin
    wrData   = '0;
    wrByteEn = '1;
    for (int k = 0; k < MAX_WORDS; k++) begin
      if (wordIdx == IDX_W'(k)) wrData = hdrWord[k];
    end
    if (wordIdx == IDX_W'(MAX_WORDS-1))
      wrByteEn = {{(WORD_BYTES/2){1'b1}}, {(WORD_BYTES/2){1'b0}}};
  end

  assign wrAddr   = hHandle + HANDLE_W'(wordIdx) * HANDLE_W'(WORD_BYTES);
  assign lastWord = hFive ? (wordIdx == IDX_W'(MAX_WORDS-1))
                          : (wordIdx == IDX_W'(MAX_WORDS-2));
  assign desc     = packDesc(hStats, hHandle, frameLen, hQid, hPort);
endmodule

// File: rtl/vlan_hdr_rewriter.sv
module vlan_hdr_rewriter
  import hdr_rw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgLoad,
  input  logic [MAC_W-1:0]      cfgMac,
  input  logic                  lkValid,
  output logic                  lkReady,
  input  logic [HANDLE_W-1:0]   lkHandle,
  input  logic [LEN_W-1:0]      lkIpLen,
  input  logic [QID_W-1:0]      lkQid,
  input  logic [VLAN_W-1:0]     lkVlan,
  input  logic [STATS_W-1:0]    lkStats,
  input  logic [BYTE_W-1:0]     lkDstByte,
  input  logic [PORT_W-1:0]     lkPort,
  input  logic                  lkFiveWr,
  output logic                  wrValid,
  input  logic                  wrReady,
  output logic [HANDLE_W-1:0]   wrAddr,
  output logic [WORD_W-1:0]     wrData,
  output logic [WORD_BYTES-1:0] wrByteEn,
  output logic                  descValid,
  input  logic                  descReady,
  output logic [DESC_W-1:0]     desc
);
  rwCtrl_t ctrl;
  logic    macLoaded;
  logic    lastWord;

  hdr_rw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .macLoaded(macLoaded), .lastWord(lastWord),
    .lkValid(lkValid), .lkReady(lkReady), .wrValid(wrValid), .wrReady(wrReady),
    .descValid(descValid), .descReady(descReady), .ctrl(ctrl)
  );

  hdr_rw_datapath u_dp (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgMac(cfgMac),
    .lkHandle(lkHandle), .lkIpLen(lkIpLen), .lkQid(lkQid), .lkVlan(lkVlan),
    .lkStats(lkStats), .lkDstByte(lkDstByte), .lkPort(lkPort), .lkFiveWr(lkFiveWr),
    .ctrl(ctrl), .macLoaded(macLoaded), .lastWord(lastWord),
    .wrAddr(wrAddr), .wrData(wrData), .wrByteEn(wrByteEn), .desc(desc)
  );
endmodule

// File: rtl/vlan_hdr_rewriter_chk.sv
module vlan_hdr_rewriter_chk
  import hdr_rw_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  cfgLoad,
  input logic [MAC_W-1:0]      cfgMac,
  input logic                  lkValid,
  input logic                  lkReady,
  input logic [HANDLE_W-1:0]   lkHandle,
  input logic [LEN_W-1:0]      lkIpLen,
  input logic                  wrValid,
  input logic                  wrReady,
  input logic [HANDLE_W-1:0]   wrAddr,
  input logic [WORD_W-1:0]     wrData,
  input logic                  descValid,
  input logic                  descReady,
  input logic [DESC_W-1:0]     desc
);
  localparam int FLEN_LSB = QID_W + 2*RSV_W + PORT_W;

  logic                cfgSeen;
  logic [MAC_W-1:0]    seenMac;
  logic [HANDLE_W-1:0] seenHandle;
  logic [LEN_W-1:0]    seenIpLen;
  logic [HANDLE_W-1:0] wrOffset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgSeen <= 1'b0; seenMac <= '0; seenHandle <= '0; seenIpLen <= '0;
    end else begin
      if (cfgLoad && !cfgSeen) begin
        cfgSeen <= 1'b1;
        seenMac <= cfgMac;
      end
      if (lkValid && lkReady) begin
        seenHandle <= lkHandle;
        seenIpLen  <= lkIpLen;
      end
    end
  end

  assign wrOffset = wrAddr - seenHandle;

  assert_no_accept_unloaded_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cfgSeen |-> !lkReady);

  assert_word0_dst_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrOffset == '0) |-> wrData == seenMac[MAC_W-1 -: WORD_W]);

  assert_word2_src_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrOffset == HANDLE_W'(2*WORD_BYTES)) |-> wrData == seenMac[WORD_W-1:0]);

  assert_frame_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    descValid |-> desc[FLEN_LSB +: LEN_W] == seenIpLen + LEN_W'(VLAN_HDR_LEN));

  assert_rsv_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    descValid |-> (desc[RSV_W+PORT_W +: RSV_W] == '0) && (desc[RSV_W-1:0] == '0));

  assert_single_flight_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid || descValid) |-> !lkReady);

  assert_one_output_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(wrValid && descValid));

  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrAddr) && $stable(wrData)));

  assert_desc_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && !descReady) |=> (descValid && $stable(desc)));

  assert_idle_after_reset_R10: assert property (@(posedge clk)
    $rose(rstN) |-> (!wrValid && !descValid && !lkReady));
endmodule

bind vlan_hdr_rewriter vlan_hdr_rewriter_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgMac(cfgMac),
  .lkValid(lkValid), .lkReady(lkReady), .lkHandle(lkHandle), .lkIpLen(lkIpLen),
  .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData),
  .descValid(descValid), .descReady(descReady), .desc(desc)
);

// File: tb/sim_vlan_hdr_rewriter.sv
module sim_vlan_hdr_rewriter;
  import hdr_rw_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0;
  logic [47:0] cfgMac = '0;
  logic lkValid = 1'b0;
  logic lkReady;
  logic [31:0] lkHandle = '0;
  logic [15:0] lkIpLen = '0;
  logic [19:0] lkQid = '0;
  logic [15:0] lkVlan = '0;
  logic [15:0] lkStats = '0;
  logic [7:0]  lkDstByte = '0;
  logic [3:0]  lkPort = '0;
  logic        lkFiveWr = 1'b0;
  logic wrValid;
  logic wrReady = 1'b0;
  logic [31:0] wrAddr;
  logic [31:0] wrData;
  logic [3:0]  wrByteEn;
  logic descValid;
  logic descReady = 1'b0;
  logic [95:0] desc;

  int checks = 0;
  int errors = 0;

  logic [47:0] macRef;
  logic [31:0] pHandle;
  logic [15:0] pIpLen, pVlan, pStats;
  logic [19:0] pQid;
  logic [7:0]  pDst;
  logic [3:0]  pPort;
  logic        pFive;

  always #5 clk = ~clk;

  vlan_hdr_rewriter u0 (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgMac(cfgMac),
    .lkValid(lkValid), .lkReady(lkReady), .lkHandle(lkHandle), .lkIpLen(lkIpLen),
    .lkQid(lkQid), .lkVlan(lkVlan), .lkStats(lkStats), .lkDstByte(lkDstByte),
    .lkPort(lkPort), .lkFiveWr(lkFiveWr), .wrValid(wrValid), .wrReady(wrReady),
    .wrAddr(wrAddr), .wrData(wrData), .wrByteEn(wrByteEn), .descValid(descValid),
    .descReady(descReady), .desc(desc)
  );

  task automatic check(input string req, input string what,
                       input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input int k);
    logic [47:0] d;
    d = {macRef[47:8], pDst};
    case (k)
      0: return d[47:16];
      1: return {d[15:0], macRef[47:32]};
      2: return macRef[31:0];
      3: return {16'h8100, pVlan};
      default: return {16'h0800, 16'h0000};
    endcase
  endfunction

  function automatic logic [95:0] expDesc();
    logic [15:0] fl;
    fl = pIpLen + 16'd18;
    return {pStats, pHandle, fl, pQid, 4'h0, pPort, 4'h0};
  endfunction

  task automatic setPacket(input logic [31:0] h, input logic [15:0] len,
                           input logic [19:0] q, input logic [15:0] v,
                           input logic [15:0] s, input logic [7:0] d,
                           input logic [3:0] p, input logic f);
    pHandle = h; pIpLen = len; pQid = q; pVlan = v;
    pStats = s; pDst = d; pPort = p; pFive = f;
  endtask

  task automatic runPacket(input bit stallWr, input bit stallDesc);
    int got = 0;
    int guard = 0;
    int nWords;
    bit held = 0;
    logic [31:0] hA, hD;
    logic [95:0] hDesc;
    string req;
    nWords = pFive ? 5 : 4;
    @(negedge clk);
    lkHandle = pHandle; lkIpLen = pIpLen; lkQid = pQid; lkVlan = pVlan;
    lkStats = pStats; lkDstByte = pDst; lkPort = pPort; lkFiveWr = pFive;
    lkValid = 1'b1;
    while (!lkReady && guard < 1000) begin @(negedge clk); guard++; end
    @(negedge clk);
    lkValid = 1'b0;
    guard = 0;
    while (got < nWords && guard < 1000) begin
      if (held) begin
        check("R9", "write held valid", {95'd0, wrValid}, 96'd1);
        check("R9", "write held addr", wrAddr, hA);
        check("R9", "write held data", wrData, hD);
        held = 0;
      end
      wrReady = stallWr ? (guard % 2 == 1) : 1'b1;
      if (wrValid) begin
        check("R8", "lkReady low while writing", {95'd0, lkReady}, 96'd0);
        if (wrReady) begin
          req = (got < 3) ? "R2" : (got == 3 ? "R3" : "R4");
          check(req, $sformatf("word %0d data", got), wrData, expWord(got));
          check("R4", $sformatf("word %0d addr", got), wrAddr, pHandle + 32'(4*got));
          check("R4", $sformatf("word %0d byteEn", got), wrByteEn,
                (got == 4) ? 4'b1100 : 4'b1111);
          got++;
        end else begin
          held = 1; hA = wrAddr; hD = wrData;
        end
      end
      @(negedge clk);
      guard++;
    end
    wrReady = 1'b0;
    check("R4", "write count", got, nWords);
    guard = 0;
    while (!descValid && guard < 100) begin @(negedge clk); guard++; end
    check("R4", "no extra write", {95'd0, wrValid}, 96'd0);
    if (stallDesc) begin
      hDesc = desc;
      repeat (3) @(negedge clk);
      check("R9", "desc held valid", {95'd0, descValid}, 96'd1);
      check("R9", "desc held value", desc, hDesc);
    end
    check("R6", "descriptor", desc, expDesc());
    check("R7", "reserved nibbles", {88'd0, desc[11:8], desc[3:0]}, 96'd0);
    descReady = 1'b1;
    @(negedge clk);
    descReady = 1'b0;
    check("R8", "desc retired", {95'd0, descValid}, 96'd0);
    check("R8", "ready for next", {95'd0, lkReady}, 96'd1);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", "lkReady in reset", {95'd0, lkReady}, 96'd0);
    check("R10", "wrValid in reset", {95'd0, wrValid}, 96'd0);
    check("R10", "descValid in reset", {95'd0, descValid}, 96'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10", "idle after reset", {93'd0, lkReady, wrValid, descValid}, 96'd0);
  endtask

  task automatic testMacLoad();
    lkValid = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "no accept before MAC load", {95'd0, lkReady}, 96'd0);
    check("R1", "no write before MAC load", {95'd0, wrValid}, 96'd0);
    lkValid = 1'b0;
    macRef = 48'h02_1A_2B_3C_4D_5E;
    cfgMac = macRef; cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0; cfgMac = '0;
    check("R1", "ready after MAC load", {95'd0, lkReady}, 96'd1);
  endtask

  task automatic testFourWrites();
    setPacket(32'h1000_0040, 16'd100, 20'hABCDE, 16'h0AAA, 16'h1234, 8'h77, 4'h9, 1'b0);
    runPacket(1'b0, 1'b0);
  endtask

  task automatic testFiveWrites();
    setPacket(32'h2000_0100, 16'd1500, 20'h00001, 16'hE123, 16'hFFFF, 8'hFE, 4'hF, 1'b1);
    runPacket(1'b0, 1'b0);
  endtask

  task automatic testBackpressure();
    setPacket(32'h3000_0200, 16'd64, 20'h54321, 16'h0005, 16'h0042, 8'h01, 4'h3, 1'b1);
    runPacket(1'b1, 1'b1);
  endtask

  task automatic testLengthWrap();
    // R5: 0xFFF0 + 18 wraps to 0x0002
    setPacket(32'h4000_0000, 16'hFFF0, 20'h0F0F0, 16'h0123, 16'h0001, 8'h00, 4'h0, 1'b0);
    runPacket(1'b0, 1'b0);
    check("R5", "wrapped length", {80'd0, pIpLen + 16'd18}, 96'h2);
  endtask

  task automatic testReloadIgnored();
    @(negedge clk);
    cfgMac = 48'hFF_EE_DD_CC_BB_AA; cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
    // R1: macRef unchanged, so packet words must still carry the first MAC
    setPacket(32'h5000_0010, 16'd200, 20'h11111, 16'h0777, 16'h0202, 8'h55, 4'h5, 1'b0);
    runPacket(1'b0, 1'b0);
  endtask

  task automatic testBackToBack();
    // R8: two packets in sequence, each checked in order
    setPacket(32'h6000_0000, 16'd40, 20'h00AAA, 16'h0010, 16'h0100, 8'h10, 4'h1, 1'b0);
    runPacket(1'b0, 1'b0);
    setPacket(32'h6000_0800, 16'd41, 20'h00BBB, 16'h0020, 16'h0101, 8'h20, 4'h2, 1'b1);
    runPacket(1'b1, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testMacLoad();
    testFourWrites();
    testFiveWrites();
    testBackpressure();
    testLengthWrap();
    testReloadIgnored();
    testBackToBack();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule